// File: doc/BRIEF.md
# Per-CPU Interrupt State Tracker

This block keeps the per-interrupt, per-CPU state that an interrupt distributor needs in order to decide what to deliver. Every interrupt line carries a CPU-wide set of bitmasks (enabled, latched pending, active, registered line level, group) and two per-line flags: a trigger-kind flag that selects edge or level sensing, and a broadcast flag that marks the source as one that every CPU sees. It also holds the priority of each source. Sources numbered below a configurable internal count keep one priority per CPU. All higher-numbered sources keep a single priority that every CPU shares.

Hardware interrupt inputs arrive as one wire per (interrupt, CPU) pair and are registered on every clock. Software-style updates come in through a one-command-per-cycle port. A combinational query port reports the effective pending bit, the active, enabled and group bits, and the priority for any chosen interrupt and CPU. For level sources the effective pending bit merges the latched bit with the live registered level. A legacy-mode input drops that merge, so only the latched bit is reported.

Top module: `irqst_tracker`

## Requirements
- R1: After synchronous reset every enabled, pending, active, group, trigger-kind, broadcast and priority value is zero, so all sources start as level-sensed.
- R2: For an edge-sensed source, a 0-to-1 change between two successive line samples for a CPU sets that CPU's latched pending bit. The bit stays set after the line falls.
- R3: With legacy mode low, a level-sensed source reads as pending for a CPU while its registered line is high, or while its latched pending bit is set.
- R4: Clearing pending (op 3) on a source whose broadcast flag is set clears the latched bit for every CPU. Without the flag, only the commanding CPU's bit is cleared.
- R5: Clearing pending on a level-sensed source whose line is still high leaves it reading as pending until the line falls.
- R6: Set-active (op 4) and clear-active (op 5) change only the commanding CPU's active bit.
- R7: A priority write (op 12) to a source below N_INTERNAL updates only the commanding CPU's copy. A write to a higher source updates the single copy that all CPUs read.
- R8: With legacy mode high, the pending query reports only the latched bit and ignores the line level.
- R9: When a rising edge and a pending-clear command hit the same bit in the same cycle, the bit ends up set.
- R10: Enable set/clear (ops 0/1) and group set/clear (ops 6/7) act only on the commanding CPU's bit. Ops 8/9 set and clear the edge flag, and ops 10/11 set and clear the broadcast flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1: pending query uses the latched bit only |
| irq_lines | input | N_IRQ*N_CPU | Line inputs, bit irq*N_CPU+cpu |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_irq | input | IRQ_W | Target interrupt |
| cmd_cpu | input | CPU_W | Commanding CPU |
| cmd_prio | input | PRIO_W | Priority value for op 12 |
| qry_irq | input | IRQ_W | Queried interrupt |
| qry_cpu | input | CPU_W | Queried CPU |
| qry_pending | output | 1 | Effective pending bit |
| qry_active | output | 1 | Active bit |
| qry_enabled | output | 1 | Enabled bit |
| qry_group | output | 1 | Group bit |
| qry_prio | output | PRIO_W | Priority seen by the queried CPU |

## Verification
The assertions assume that cmd_irq and qry_irq stay below N_IRQ and that cmd_cpu and qry_cpu stay below N_CPU. The checks on pending clears and active sets also assume a known command opcode. The stimulus keeps within these limits. It uses only named opcodes, drives in-range indices, and changes lines and commands one clock edge apart. The single exception is the deliberate collision case, where a rising edge and a clear land on the same edge.

// File: rtl/irqst_pkg.sv
package irqst_pkg;

    typedef enum logic [3:0] {
        OP_EN_SET    = 4'd0,
        OP_EN_CLR    = 4'd1,
        OP_PEND_SET  = 4'd2,
        OP_PEND_CLR  = 4'd3,
        OP_ACT_SET   = 4'd4,
        OP_ACT_CLR   = 4'd5,
        OP_GRP_SET   = 4'd6,
        OP_GRP_CLR   = 4'd7,
        OP_EDGE_SET  = 4'd8,
        OP_EDGE_CLR  = 4'd9,
        OP_BCAST_SET = 4'd10,
        OP_BCAST_CLR = 4'd11,
        OP_PRIO_WR   = 4'd12
    } irq_op_e;

    // One-hot style decoded form of a command, applied to one line
    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic set_pend;
        logic clr_pend;
        logic set_act;
        logic clr_act;
        logic set_grp;
        logic clr_grp;
        logic set_edge;
        logic clr_edge;
        logic set_bcast;
        logic clr_bcast;
        logic wr_prio;
    } line_cmd_t;

    function automatic line_cmd_t decode_op(input logic valid, input logic [3:0] op);
        line_cmd_t c;
        c = '0;
        if (valid) begin
            case (op)
                OP_EN_SET:    c.set_en    = 1'b1;
                OP_EN_CLR:    c.clr_en    = 1'b1;
                OP_PEND_SET:  c.set_pend  = 1'b1;
                OP_PEND_CLR:  c.clr_pend  = 1'b1;
                OP_ACT_SET:   c.set_act   = 1'b1;
                OP_ACT_CLR:   c.clr_act   = 1'b1;
                OP_GRP_SET:   c.set_grp   = 1'b1;
                OP_GRP_CLR:   c.clr_grp   = 1'b1;
                OP_EDGE_SET:  c.set_edge  = 1'b1;
                OP_EDGE_CLR:  c.clr_edge  = 1'b1;
                OP_BCAST_SET: c.set_bcast = 1'b1;
                OP_BCAST_CLR: c.clr_bcast = 1'b1;
                OP_PRIO_WR:   c.wr_prio   = 1'b1;
                default:      c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/irqst_sampler.sv
module irqst_sampler #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lines,
    output logic [WIDTH-1:0] lvl_q,
    output logic [WIDTH-1:0] rise
);
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lines;
    end

    // A rise is a high input that was low at the previous sample
    assign rise = lines & ~lvl_q;
endmodule

// File: rtl/irqst_line.sv
module irqst_line
    import irqst_pkg::*;
#(
    parameter int N_CPU = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  line_cmd_t        cmd,
    input  logic [N_CPU-1:0] cpu_sel,
    input  logic [N_CPU-1:0] rise_eff,
    output logic [N_CPU-1:0] en_q,
    output logic [N_CPU-1:0] pend_q,
    output logic [N_CPU-1:0] act_q,
    output logic [N_CPU-1:0] grp_q,
    output logic             edge_q,
    output logic             bcast_q
);
    localparam logic [N_CPU-1:0] ALL_CPUS = {N_CPU{1'b1}};

    logic [N_CPU-1:0] pend_set, pend_clr;

    always_comb begin
        pend_set = rise_eff;
        pend_clr = '0;
        if (hit && cmd.set_pend) pend_set = pend_set | cpu_sel;
        if (hit && cmd.clr_pend) pend_clr = bcast_q ? ALL_CPUS : cpu_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            pend_q  <= '0;
            act_q   <= '0;
            grp_q   <= '0;
            edge_q  <= 1'b0;
            bcast_q <= 1'b0;
        end else begin
            // set is applied after clear so it wins on a collision
            pend_q <= (pend_q & ~pend_clr) | pend_set;
            if (hit) begin
                if (cmd.set_en)    en_q    <= en_q | cpu_sel;
                if (cmd.clr_en)    en_q    <= en_q & ~cpu_sel;
                if (cmd.set_act)   act_q   <= act_q | cpu_sel;
                if (cmd.clr_act)   act_q   <= act_q & ~cpu_sel;
                if (cmd.set_grp)   grp_q   <= grp_q | cpu_sel;
                if (cmd.clr_grp)   grp_q   <= grp_q & ~cpu_sel;
                if (cmd.set_edge)  edge_q  <= 1'b1;
                if (cmd.clr_edge)  edge_q  <= 1'b0;
                if (cmd.set_bcast) bcast_q <= 1'b1;
                if (cmd.clr_bcast) bcast_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irqst_prio.sv
module irqst_prio #(
    parameter int N_IRQ      = 16,
    parameter int N_CPU      = 2,
    parameter int N_INTERNAL = 8,
    parameter int PRIO_W     = 8,
    parameter int IRQ_W      = 4,
    parameter int CPU_W      = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IRQ_W-1:0]  wr_irq,
    input  logic [CPU_W-1:0]  wr_cpu,
    input  logic [PRIO_W-1:0] wr_val,
    input  logic [IRQ_W-1:0]  rd_irq,
    input  logic [CPU_W-1:0]  rd_cpu,
    output logic [PRIO_W-1:0] rd_val
);
    localparam int N_SHARED = N_IRQ - N_INTERNAL;

    logic [PRIO_W-1:0] banked [N_INTERNAL][N_CPU];
    logic [PRIO_W-1:0] shared [N_SHARED];

    for (genvar i = 0; i < N_INTERNAL; i++) begin : g_bank_irq
        for (genvar c = 0; c < N_CPU; c++) begin : g_bank_cpu
            always_ff @(posedge clk) begin
                if (rst) banked[i][c] <= '0;
                else if (wr && wr_irq == IRQ_W'(i) && wr_cpu == CPU_W'(c))
                    banked[i][c] <= wr_val;
            end
        end
    end

    for (genvar s = 0; s < N_SHARED; s++) begin : g_shared
        always_ff @(posedge clk) begin
            if (rst) shared[s] <= '0;
            else if (wr && wr_irq == IRQ_W'(s + N_INTERNAL))
                shared[s] <= wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_INTERNAL; i++)
            for (int c = 0; c < N_CPU; c++)
                if (rd_irq == IRQ_W'(i) && rd_cpu == CPU_W'(c)) rd_val = banked[i][c];
        for (int s = 0; s < N_SHARED; s++)
            if (rd_irq == IRQ_W'(s + N_INTERNAL)) rd_val = shared[s];
    end
endmodule

// File: rtl/irqst_tracker.sv
module irqst_tracker
    import irqst_pkg::*;
#(
    parameter int N_IRQ      = 16,
    parameter int N_CPU      = 2,
    parameter int N_INTERNAL = 8,
    parameter int PRIO_W     = 8,
    localparam int IRQ_W     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int CPU_W     = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   legacy_mode,
    input  logic [N_IRQ*N_CPU-1:0] irq_lines,
    input  logic                   cmd_valid,
    input  logic [3:0]             cmd_op,
    input  logic [IRQ_W-1:0]       cmd_irq,
    input  logic [CPU_W-1:0]       cmd_cpu,
    input  logic [PRIO_W-1:0]      cmd_prio,
    input  logic [IRQ_W-1:0]       qry_irq,
    input  logic [CPU_W-1:0]       qry_cpu,
    output logic                   qry_pending,
    output logic                   qry_active,
    output logic                   qry_enabled,
    output logic                   qry_group,
    output logic [PRIO_W-1:0]      qry_prio
);
    localparam int NB    = N_IRQ * N_CPU;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    line_cmd_t         cmd_dec;
    logic [N_CPU-1:0]  cpu_sel;
    logic [NB-1:0]     lvl_flat, rise_raw, rise_eff;
    logic [NB-1:0]     en_flat, pend_flat, act_flat, grp_flat, eff_flat;
    logic [N_IRQ-1:0]  edge_vec, bcast_vec;
    logic [IDX_W-1:0]  sel_idx;

    assign cmd_dec = decode_op(cmd_valid, cmd_op);
    assign cpu_sel = N_CPU'(1) << cmd_cpu;

    irqst_sampler #(.WIDTH(NB)) i_sampler (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_lines),
        .lvl_q (lvl_flat),
        .rise  (rise_raw)
    );

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        localparam int LO = i * N_CPU;
        assign rise_eff[LO +: N_CPU] = edge_vec[i] ? rise_raw[LO +: N_CPU] : '0;
        // level sources merge the registered line unless legacy mode is on
        assign eff_flat[LO +: N_CPU] = legacy_mode ? pend_flat[LO +: N_CPU]
            : pend_flat[LO +: N_CPU] | (edge_vec[i] ? '0 : lvl_flat[LO +: N_CPU]);

        irqst_line #(.N_CPU(N_CPU)) i_line (
            .clk      (clk),
            .rst      (rst),
            .hit      (cmd_irq == IRQ_W'(i)),
            .cmd      (cmd_dec),
            .cpu_sel  (cpu_sel),
            .rise_eff (rise_eff[LO +: N_CPU]),
            .en_q     (en_flat[LO +: N_CPU]),
            .pend_q   (pend_flat[LO +: N_CPU]),
            .act_q    (act_flat[LO +: N_CPU]),
            .grp_q    (grp_flat[LO +: N_CPU]),
            .edge_q   (edge_vec[i]),
            .bcast_q  (bcast_vec[i])
        );
    end

    irqst_prio #(
        .N_IRQ(N_IRQ), .N_CPU(N_CPU), .N_INTERNAL(N_INTERNAL),
        .PRIO_W(PRIO_W), .IRQ_W(IRQ_W), .CPU_W(CPU_W)
    ) i_prio (
        .clk    (clk),
        .rst    (rst),
        .wr     (cmd_dec.wr_prio),
        .wr_irq (cmd_irq),
        .wr_cpu (cmd_cpu),
        .wr_val (cmd_prio),
        .rd_irq (qry_irq),
        .rd_cpu (qry_cpu),
        .rd_val (qry_prio)
    );

    assign sel_idx     = IDX_W'(int'(qry_irq) * N_CPU + int'(qry_cpu));
    assign qry_pending = eff_flat[sel_idx];
    assign qry_active  = act_flat[sel_idx];
    assign qry_enabled = en_flat[sel_idx];
    assign qry_group   = grp_flat[sel_idx];
endmodule

// File: rtl/irqst_tracker_chk.sv
module irqst_tracker_chk
    import irqst_pkg::*;
#(
    parameter int N_IRQ = 16,
    parameter int N_CPU = 2,
    parameter int IRQ_W = 4,
    parameter int CPU_W = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   legacy_mode,
    input logic                   cmd_valid,
    input logic [3:0]             cmd_op,
    input logic [IRQ_W-1:0]       cmd_irq,
    input logic [CPU_W-1:0]       cmd_cpu,
    input logic [IRQ_W-1:0]       qry_irq,
    input logic [CPU_W-1:0]       qry_cpu,
    input logic                   qry_pending,
    input logic [N_IRQ*N_CPU-1:0] pend_flat,
    input logic [N_IRQ*N_CPU-1:0] act_flat,
    input logic [N_IRQ*N_CPU-1:0] lvl_flat,
    input logic [N_IRQ*N_CPU-1:0] rise_eff,
    input logic [N_IRQ-1:0]       edge_vec,
    input logic [N_IRQ-1:0]       bcast_vec
);
    logic [IRQ_W-1:0] irq_d;
    logic [CPU_W-1:0] cpu_d;
    int               q_idx;

    always_ff @(posedge clk) begin
        irq_d <= cmd_irq;
        cpu_d <= cmd_cpu;
    end

    assign q_idx = int'(qry_irq) * N_CPU + int'(qry_cpu);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pend_flat == '0 && act_flat == '0));

    a_r2_edge_latches: assert property (@(posedge clk) disable iff (rst)
        (rise_eff != '0) |=> ((pend_flat & $past(rise_eff)) == $past(rise_eff)));

    a_r4_bcast_clear_all: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PEND_CLR && bcast_vec[cmd_irq]
         && rise_eff[int'(cmd_irq)*N_CPU +: N_CPU] == '0)
        |=> (pend_flat[int'(irq_d)*N_CPU +: N_CPU] == '0));

    a_r6_active_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ACT_SET)
        |=> act_flat[int'(irq_d)*N_CPU + int'(cpu_d)]);

    a_r3_level_pending: assert property (@(posedge clk) disable iff (rst)
        (!legacy_mode && !edge_vec[qry_irq] && lvl_flat[q_idx]) |-> qry_pending);

    a_r8_legacy_latched: assert property (@(posedge clk) disable iff (rst)
        legacy_mode |-> (qry_pending == pend_flat[q_idx]));
endmodule

bind irqst_tracker irqst_tracker_chk #(
    .N_IRQ(N_IRQ), .N_CPU(N_CPU), .IRQ_W(IRQ_W), .CPU_W(CPU_W)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .legacy_mode (legacy_mode),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_irq     (cmd_irq),
    .cmd_cpu     (cmd_cpu),
    .qry_irq     (qry_irq),
    .qry_cpu     (qry_cpu),
    .qry_pending (qry_pending),
    .pend_flat   (pend_flat),
    .act_flat    (act_flat),
    .lvl_flat    (lvl_flat),
    .rise_eff    (rise_eff),
    .edge_vec    (edge_vec),
    .bcast_vec   (bcast_vec)
);

// File: tb/test_irqst_tracker.sv
`timescale 1ns/1ps
module test_irqst_tracker;
    import irqst_pkg::*;

    localparam int N_IRQ = 16, N_CPU = 2, N_INTERNAL = 8, PRIO_W = 8;
    localparam int IRQ_W = 4, CPU_W = 1;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   legacy_mode = 1'b0;
    logic [N_IRQ*N_CPU-1:0] irq_lines = '0;
    logic                   cmd_valid = 1'b0;
    logic [3:0]             cmd_op = '0;
    logic [IRQ_W-1:0]       cmd_irq = '0;
    logic [CPU_W-1:0]       cmd_cpu = '0;
    logic [PRIO_W-1:0]      cmd_prio = '0;
    logic [IRQ_W-1:0]       qry_irq = '0;
    logic [CPU_W-1:0]       qry_cpu = '0;
    logic                   qry_pending, qry_active, qry_enabled, qry_group;
    logic [PRIO_W-1:0]      qry_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string req;
        int    kind;
        int    exp;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    irqst_tracker #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .N_INTERNAL(N_INTERNAL), .PRIO_W(PRIO_W)) i_irqst_tracker (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .irq_lines(irq_lines),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_irq(cmd_irq), .cmd_cpu(cmd_cpu),
        .cmd_prio(cmd_prio), .qry_irq(qry_irq), .qry_cpu(qry_cpu),
        .qry_pending(qry_pending), .qry_active(qry_active), .qry_enabled(qry_enabled),
        .qry_group(qry_group), .qry_prio(qry_prio)
    );

    // Monitor: compares the oldest expectation on the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            int   act;
            e = sb.pop_front();
            case (e.kind)
                0:       act = int'(qry_pending);
                1:       act = int'(qry_active);
                2:       act = int'(qry_enabled);
                3:       act = int'(qry_group);
                default: act = int'(qry_prio);
            endcase
            checks++;
            if (act != e.exp) begin
                fails++;
                $display("FAIL %s: actual %0d expected %0d", e.req, act, e.exp);
            end
        end
    end

    task automatic cmd(input irq_op_e op, input int irq, input int cpu, input int prio = 0);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = op; cmd_irq = IRQ_W'(irq);
        cmd_cpu = CPU_W'(cpu); cmd_prio = PRIO_W'(prio);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic line(input int irq, input int cpu, input bit v);
        @(posedge clk); #1;
        irq_lines[irq*N_CPU + cpu] = v;
        @(posedge clk); #1;
    endtask

    // Driver: sets the query and pushes the expected value
    task automatic expect_q(input string req, input int kind, input int irq, input int cpu, input int exp);
        @(posedge clk); #1;
        qry_irq = IRQ_W'(irq); qry_cpu = CPU_W'(cpu);
        sb.push_back('{req, kind, exp});
        @(negedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_q("R1 pending", 0, 3, 0, 0);
        expect_q("R1 active", 1, 3, 1, 0);
        expect_q("R1 prio", 4, 9, 0, 0);

        // R2 edge latch on cpu1 only
        cmd(OP_EDGE_SET, 10, 0);
        line(10, 1, 1'b1);
        line(10, 1, 1'b0);
        expect_q("R2 latched after fall", 0, 10, 1, 1);
        expect_q("R2 other cpu", 0, 10, 0, 0);

        // R3 level follows line, software set
        line(4, 0, 1'b1);
        expect_q("R3 level high", 0, 4, 0, 1);
        line(4, 0, 1'b0);
        expect_q("R3 level low", 0, 4, 0, 0);
        cmd(OP_PEND_SET, 4, 0);
        expect_q("R3 software set", 0, 4, 0, 1);
        cmd(OP_PEND_CLR, 4, 0);
        expect_q("R3 software clear", 0, 4, 0, 0);

        // R5 clear with line high
        line(5, 1, 1'b1);
        cmd(OP_PEND_SET, 5, 1);
        cmd(OP_PEND_CLR, 5, 1);
        expect_q("R5 still pending", 0, 5, 1, 1);
        line(5, 1, 1'b0);
        expect_q("R5 released", 0, 5, 1, 0);

        // R4 broadcast clear vs per-cpu clear
        cmd(OP_BCAST_SET, 12, 0);
        cmd(OP_PEND_SET, 12, 0);
        cmd(OP_PEND_SET, 12, 1);
        cmd(OP_PEND_CLR, 12, 0);
        expect_q("R4 bcast cpu1 cleared", 0, 12, 1, 0);
        expect_q("R4 bcast cpu0 cleared", 0, 12, 0, 0);
        cmd(OP_PEND_SET, 13, 0);
        cmd(OP_PEND_SET, 13, 1);
        cmd(OP_PEND_CLR, 13, 0);
        expect_q("R4 local cpu0 cleared", 0, 13, 0, 0);
        expect_q("R4 local cpu1 kept", 0, 13, 1, 1);

        // R6 active per cpu
        cmd(OP_ACT_SET, 2, 1);
        expect_q("R6 set cpu1", 1, 2, 1, 1);
        expect_q("R6 cpu0 untouched", 1, 2, 0, 0);
        cmd(OP_ACT_SET, 2, 0);
        cmd(OP_ACT_CLR, 2, 1);
        expect_q("R6 clr cpu1", 1, 2, 1, 0);
        expect_q("R6 cpu0 kept", 1, 2, 0, 1);

        // R7 banked and shared priority
        cmd(OP_PRIO_WR, 3, 0, 8'h40);
        cmd(OP_PRIO_WR, 3, 1, 8'h80);
        expect_q("R7 banked cpu0", 4, 3, 0, 8'h40);
        expect_q("R7 banked cpu1", 4, 3, 1, 8'h80);
        cmd(OP_PRIO_WR, 9, 0, 8'h20);
        expect_q("R7 shared seen by cpu1", 4, 9, 1, 8'h20);
        cmd(OP_PRIO_WR, 9, 1, 8'h30);
        expect_q("R7 shared seen by cpu0", 4, 9, 0, 8'h30);

        // R8 legacy ignores level
        line(6, 0, 1'b1);
        legacy_mode = 1'b1;
        expect_q("R8 legacy ignores line", 0, 6, 0, 0);
        legacy_mode = 1'b0;
        expect_q("R8 normal merges line", 0, 6, 0, 1);
        line(6, 0, 1'b0);

        // R9 edge and clear collide: set wins
        cmd(OP_EDGE_SET, 11, 0);
        @(posedge clk); #1;
        irq_lines[11*N_CPU + 0] = 1'b1;
        cmd_valid = 1'b1; cmd_op = OP_PEND_CLR; cmd_irq = 4'd11; cmd_cpu = 1'b0;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        irq_lines[11*N_CPU + 0] = 1'b0;
        expect_q("R9 set wins", 0, 11, 0, 1);

        // R10 enable and group per cpu
        cmd(OP_EN_SET, 1, 0);
        expect_q("R10 enable cpu0", 2, 1, 0, 1);
        expect_q("R10 enable cpu1 untouched", 2, 1, 1, 0);
        cmd(OP_GRP_SET, 1, 1);
        expect_q("R10 group cpu1", 3, 1, 1, 1);
        expect_q("R10 group cpu0 untouched", 3, 1, 0, 0);
        cmd(OP_EN_CLR, 1, 0);
        expect_q("R10 enable cleared", 2, 1, 0, 0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule